// File: doc/BRIEF.md
# Multi-Channel Tick Timer Unit

This block is a register-mapped timer peripheral. It contains four independent 16-bit countdown channels (A, B, C and D) and one 32-bit up-counting timestamp channel (E). A prescaler divides the system clock into a 1 us tick. A chain of decade dividers then produces 10 us, 100 us and 1 ms ticks from that 1 us tick. The frequency of the system clock is a parameter.

Each countdown channel picks one of these ticks as its timebase. It runs either once (one-shot) or with automatic reload (periodic), and it raises its own one-cycle interrupt pulse each time it expires. The timestamp channel counts up on the tick it selects, which may also be the raw system clock. Software can read it at any time.

A single control word holds the run enables, the modes and the timebase selects for all channels. Software reaches the control word and the per-channel count registers through a plain write/read port. Reads are combinational. Writes take effect on the clock edge.

Top module: `timer_unit`

## Requirements
- R1: Reset clears the control word, all four countdown counters and the timestamp. While reset is active, every register reads zero and all interrupt outputs are low.
- R2: Register index is `addr[7:2]`, and only addresses with `addr[1:0]==0` are decoded. Index 0 is the control word, indices 1 to 4 are the count registers of channels A to D, and index 5 is the timestamp. A write to a count register loads both its counter and its reload value with `wrData[15:0]`, and a read of that register returns the live counter value. Unmapped or misaligned addresses read zero.
- R3: Control word layout:
  - bits 19..16 are the run enables of channels A to D;
  - bits 15..12 are the modes of channels A to D (1 = periodic, 0 = one-shot);
  - bits [1:0], [3:2], [5:4] and [7:6] are the timebase fields of channels A to D;
  - bits [10:8] are the timestamp timebase field.
  
  Bit 11 and bits 31..20 always read zero.
- R4: In a channel A to D timebase field, code 0 selects the 1 us tick, 1 selects 10 us, 2 selects 100 us and 3 selects 1 ms. The ticks are derived from `CLK_HZ`.
- R5: An enabled countdown channel decrements once per selected tick. It expires on a tick that finds its counter at zero. A register load in the same cycle takes priority over the tick.
- R6: In periodic mode, a loaded value N produces one expiry every N+1 ticks, with the counter reloaded to N on each expiry.
- R7: In one-shot mode, the expiry clears that channel's enable bit in the control word, and the counter stays at zero. No further interrupt occurs until software re-enables the channel.
- R8: While a channel's enable bit is clear, its counter holds its value and its interrupt stays low.
- R9: The timestamp increments by exactly one on each selected tick. Its field codes 0 to 4 select the system clock, 1 us, 10 us, 100 us and 1 ms. Codes 5 to 7 hold the value.
- R10: Writes to the timestamp address are ignored.
- R11: Every expiry drives a one-cycle pulse on that channel's own `irq` bit, one cycle after the expiring tick, and on no other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W (8) | Byte address of the register |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Combinational read data for `addr` |
| irq | output | 4 | Per-channel expiry pulses, bit 0 = channel A |

## Verification
The bench builds the unit with `CLK_HZ` set to 4 MHz, which gives four system-clock cycles per microsecond. At that setting a 1 ms tick arrives every 4000 cycles, so periodic intervals on all four countdown timebases can be timed exactly in cycles. The same setting lets the timestamp be measured across all five of its rates. The channel width stays at its default of 16 bits. Exact-interval checks rely on measuring between two expiries, so they do not depend on the prescaler phase. The one-shot latency check accepts the one-tick window that this phase allows.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NCH   = 4;   // countdown channels
  localparam int NBASE = 4;   // 1us, 10us, 100us, 1ms
  localparam int CTRL_W     = 20;
  localparam int EN_LSB     = 16;
  localparam int MODE_LSB   = 12;
  localparam int TSSEL_LSB  = 8;
  localparam int TSSEL_W    = 3;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 20'hFF7FF;

  typedef struct packed {
    logic [NCH-1:0] load;      // count register written this cycle
    logic [NCH-1:0] tick;      // selected tick and channel enabled
    logic [NCH-1:0] periodic;  // reload on expiry
    logic           tsTick;    // timestamp advance
  } strobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int CNT_W  = 16,
  parameter int TS_W   = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [NCH-1:0][CNT_W-1:0] cntVal,
  input  logic [TS_W-1:0]           tsVal,
  input  logic [NCH-1:0]            expire,
  output logic [DATA_W-1:0]         rdData,
  output logic [CTRL_W-1:0]         ctrlWord,
  output strobe_t                   strb
);
  localparam int CYC_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int US_W   = (CYC_US > 1) ? $clog2(CYC_US) : 1;
  localparam int IDX_W  = ADDR_W - 2;
  localparam logic [IDX_W-1:0] TS_IDX = IDX_W'(NCH + 1);

  // tick prescaler: 1us divider followed by decade stages
  logic [US_W-1:0] usCnt;
  logic            baseTick [NBASE];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                           usCnt <= '0;
    else if (usCnt == US_W'(CYC_US - 1)) usCnt <= '0;
    else                                 usCnt <= usCnt + 1'b1;

  assign baseTick[0] = (usCnt == US_W'(CYC_US - 1));

  for (genvar k = 0; k < NBASE - 1; k++) begin : g_decade
    logic [3:0] dec;
    always_ff @(posedge clk or negedge rstN)
      if (!rstN)            dec <= '0;
      else if (baseTick[k]) dec <= (dec == 4'd9) ? 4'd0 : dec + 4'd1;
    assign baseTick[k+1] = baseTick[k] && (dec == 4'd9);
  end

  // register decode
  logic [IDX_W-1:0] regIdx;
  logic             aligned, ctrlWr;
  logic [CTRL_W-1:0] ctrlQ;

  assign regIdx  = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign ctrlWr  = wrEn && aligned && (regIdx == '0);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= wrData[CTRL_W-1:0] & CTRL_MASK;
    else
      for (int i = 0; i < NCH; i++)
        if (expire[i] && !ctrlQ[MODE_LSB+i]) ctrlQ[EN_LSB+i] <= 1'b0;

  assign ctrlWord = ctrlQ;

  // strobes to the datapath
  logic [TSSEL_W-1:0] tsSel;
  assign tsSel = ctrlQ[TSSEL_LSB +: TSSEL_W];

  always_comb begin
    strb = '0;
    for (int i = 0; i < NCH; i++) begin
      strb.load[i]     = wrEn && aligned && (regIdx == IDX_W'(i + 1));
      strb.tick[i]     = ctrlQ[EN_LSB+i] && baseTick[ctrlQ[2*i +: 2]];
      strb.periodic[i] = ctrlQ[MODE_LSB+i];
    end
    case (tsSel)
      3'd0:    strb.tsTick = 1'b1;
      3'd1:    strb.tsTick = baseTick[0];
      3'd2:    strb.tsTick = baseTick[1];
      3'd3:    strb.tsTick = baseTick[2];
      3'd4:    strb.tsTick = baseTick[3];
      default: strb.tsTick = 1'b0;
    endcase
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (aligned) begin
      if (regIdx == '0) rdData = DATA_W'(ctrlQ);
      if (regIdx == TS_IDX) rdData = DATA_W'(tsVal);
      for (int i = 0; i < NCH; i++)
        if (regIdx == IDX_W'(i + 1)) rdData = DATA_W'(cntVal[i]);
    end
  end
endmodule

// File: rtl/timer_dp.sv
module timer_dp
  import timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TS_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [CNT_W-1:0]          loadVal,
  output logic [NCH-1:0][CNT_W-1:0] cntVal,
  output logic [TS_W-1:0]           tsVal,
  output logic [NCH-1:0]            expire,
  output logic [NCH-1:0]            irq
);
  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [CNT_W-1:0] reload, cnt;

    assign expire[i] = strb.tick[i] && !strb.load[i] && (cnt == '0);
    assign cntVal[i] = cnt;

    always_ff @(posedge clk or negedge rstN)
      if (!rstN) begin
        reload <= '0;
        cnt    <= '0;
      end else if (strb.load[i]) begin
        reload <= loadVal;
        cnt    <= loadVal;
      end else if (strb.tick[i]) begin
        if (cnt != '0)               cnt <= cnt - 1'b1;
        else if (strb.periodic[i])   cnt <= reload;
      end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) irq <= '0;
    else       irq <= expire;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            tsVal <= '0;
    else if (strb.tsTick) tsVal <= tsVal + 1'b1;
endmodule

// File: rtl/timer_unit.sv
module timer_unit
  import timer_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int CNT_W  = 16,
  parameter int TS_W   = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NCH-1:0]    irq
);
  strobe_t                   strb;
  logic [NCH-1:0][CNT_W-1:0] cntVal;
  logic [TS_W-1:0]           tsVal;
  logic [NCH-1:0]            expire;
  logic [CTRL_W-1:0]         ctrlWord;

  timer_ctrl #(
    .CLK_HZ(CLK_HZ), .CNT_W(CNT_W), .TS_W(TS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cntVal(cntVal), .tsVal(tsVal), .expire(expire),
    .rdData(rdData), .ctrlWord(ctrlWord), .strb(strb)
  );

  timer_dp #(.CNT_W(CNT_W), .TS_W(TS_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(wrData[CNT_W-1:0]),
    .cntVal(cntVal), .tsVal(tsVal), .expire(expire), .irq(irq)
  );
endmodule

// File: rtl/timer_unit_chk.sv
module timer_unit_chk
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TS_W   = 32,
  parameter int ADDR_W = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic [ADDR_W-1:0]         addr,
  input logic [NCH-1:0]            irq,
  input logic [CTRL_W-1:0]         ctrlWord,
  input logic [NCH-1:0]            loadMask,
  input logic [NCH-1:0][CNT_W-1:0] cntVal,
  input logic [TS_W-1:0]           tsVal
);
  logic [NCH-1:0] enBits, modeBits;
  logic           ctrlWr;
  assign enBits   = ctrlWord[EN_LSB +: NCH];
  assign modeBits = ctrlWord[MODE_LSB +: NCH];
  assign ctrlWr   = wrEn && (addr == '0);

  // R8: an interrupt only follows a cycle in which its channel was enabled
  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|irq) |-> ((irq & ~$past(enBits)) == '0));

  // R7: a one-shot expiry leaves the channel disabled
  assert_oneshot_stops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (((irq & ~$past(modeBits)) != '0) && !$past(ctrlWr))
      |-> ((irq & ~$past(modeBits) & enBits) == '0));

  // R9: the timestamp only ever steps by one
  assert_ts_single_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tsVal != $past(tsVal)) |-> (tsVal == $past(tsVal) + 1'b1));

  for (genvar i = 0; i < NCH; i++) begin : g_frz
    // R8: a disabled, unloaded channel holds its count
    assert_frozen_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(enBits[i]) && !$past(loadMask[i])) |-> $stable(cntVal[i]));
  end
endmodule

bind timer_unit timer_unit_chk #(.CNT_W(CNT_W), .TS_W(TS_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .irq(irq),
  .ctrlWord(ctrlWord), .loadMask(strb.load), .cntVal(cntVal), .tsVal(tsVal)
);

// File: tb/timer_unit_test.sv
module timer_unit_test;
  localparam int CLK_HZ = 4_000_000;

  logic        clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irq;
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;  // 250 MHz

  timer_unit #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // {channel, timebase code, load value, expected interval in cycles}
  localparam logic [35:0] VEC [6] = '{
    {2'd0, 2'd0, 16'd9,   16'd40},
    {2'd1, 2'd1, 16'd3,   16'd160},
    {2'd2, 2'd2, 16'd1,   16'd800},
    {2'd3, 2'd3, 16'd0,   16'd4000},
    {2'd0, 2'd0, 16'd999, 16'd4000},
    {2'd2, 2'd0, 16'd0,   16'd4}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic waitIrq(int ch, int maxC, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq[ch] && n < maxC);
  endtask

  initial begin
    repeat (1_900_00) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] v, v0, v1;
    int n, m;
    // R1: registers read zero in reset
    repeat (3) @(negedge clk);
    for (int a = 0; a <= 5; a++) begin
      peek(8'(a * 4), v);
      check("R1 reset value", v, 0);
    end
    check("R1 irq in reset", 32'(irq), 0);
    @(negedge clk); rstN = 1'b1;

    // R3: unused control bits read zero
    wr(8'h00, 32'hFFFF_FFFF);
    peek(8'h00, v);
    check("R3 control layout", v, 32'h000F_F7FF);
    wr(8'h00, 32'h0);

    // R2: load and readback, truncation, unmapped addresses
    wr(8'h04, 32'hABCD_1234);
    peek(8'h04, v); check("R2 load A", v, 32'h1234);
    wr(8'h10, 32'h0000_FFFE);
    peek(8'h10, v); check("R2 load D max", v, 32'hFFFE);
    peek(8'h18, v); check("R2 unmapped", v, 0);
    peek(8'h06, v); check("R2 misaligned", v, 0);

    // R4 R5 R6 R11: table of periodic intervals
    foreach (VEC[k]) begin
      int ch, tb, nv, iv;
      logic other, longPulse;
      ch = int'(VEC[k][35:34]); tb = int'(VEC[k][33:32]);
      nv = int'(VEC[k][31:16]); iv = int'(VEC[k][15:0]);
      wr(8'h00, 32'h0);
      wr(8'(4 + 4 * ch), 32'(nv));
      wr(8'h00, (32'd1 << (16 + ch)) | (32'd1 << (12 + ch)) | (32'(tb) << (2 * ch)));
      waitIrq(ch, 3 * iv + 10, n);
      check("R5 expiry seen", 32'(irq[ch]), 1);
      m = 0; other = 1'b0; longPulse = 1'b0;
      do begin
        @(negedge clk); m++;
        if ((irq & ~(4'd1 << ch)) != 4'd0) other = 1'b1;
        if (m == 1 && irq[ch] && iv > 1) longPulse = 1'b1;
      end while (!irq[ch] && m < 3 * iv);
      check("R6 R4 period", 32'(m), 32'(iv));
      check("R11 other channels quiet", 32'(other), 0);
      check("R11 single-cycle pulse", 32'(longPulse), 0);
    end
    wr(8'h00, 32'h0);

    // R7: one-shot on channel C, 1 us base, value 5
    wr(8'h0C, 32'd5);
    wr(8'h00, 32'd1 << 18);
    waitIrq(2, 100, n);
    check("R7 one-shot latency", 32'(n >= 21 && n <= 24), 1);
    @(negedge clk);
    check("R11 one-shot pulse ends", 32'(irq[2]), 0);
    peek(8'h00, v); check("R7 enable cleared", v, 0);
    peek(8'h0C, v); check("R7 counter stays zero", v, 0);
    waitIrq(2, 200, n);
    check("R7 no second irq", 32'(irq[2]), 0);

    // R8: freeze on disable, resume on enable
    wr(8'h08, 32'd100);
    wr(8'h00, (32'd1 << 17) | (32'd1 << 13));
    repeat (40) @(negedge clk);
    wr(8'h00, 32'd1 << 13);
    peek(8'h08, v0);
    check("R8 counted while enabled", 32'(v0 >= 85 && v0 <= 95), 1);
    begin
      logic hit;
      hit = 1'b0;
      for (int c = 0; c < 400; c++) begin @(negedge clk); if (irq[1]) hit = 1'b1; end
      check("R8 no irq while disabled", 32'(hit), 0);
    end
    peek(8'h08, v1); check("R8 count frozen", v1, v0);
    wr(8'h00, (32'd1 << 17) | (32'd1 << 13));
    repeat (40) @(negedge clk);
    peek(8'h08, v1); check("R8 resumes", 32'(v1 != v0), 1);
    wr(8'h00, 32'h0);

    // R9: timestamp rates
    begin
      int codes [5] = '{0, 1, 2, 3, 4};
      int span  [5] = '{400, 400, 4000, 40000, 40000};
      int expd  [5] = '{400, 100, 100, 100, 10};
      for (int i = 0; i < 5; i++) begin
        wr(8'h00, 32'(codes[i]) << 8);
        peek(8'h14, v0);
        repeat (span[i]) @(negedge clk);
        peek(8'h14, v1);
        check("R9 timestamp rate", v1 - v0, 32'(expd[i]));
      end
    end
    wr(8'h00, 32'd5 << 8);
    peek(8'h14, v0);
    repeat (400) @(negedge clk);
    peek(8'h14, v1); check("R9 code 5 holds", v1, v0);

    // R10: timestamp write ignored
    wr(8'h14, 32'h1234_5678);
    peek(8'h14, v1); check("R10 write ignored", v1, v0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule